// File: doc/BRIEF.md
# Sticky Fault Status and Interrupt Register

This block gathers six single-cycle fault events from a receive path and its local memory into sticky flags held in one 32-bit status word. Software reads the word to learn which faults have happened. It clears a flag by writing a zero to that flag's position. Writing a one to a flag leaves it alone. A separate 32-bit mask word selects which flags may raise the interrupt line.

A global interrupt enable lives in the same status word. Any read strobe on the status word drops this enable at the next clock edge, but the data returned by that read still shows the enable as it was. This allows a handler to read the word, then write back the same value with zeros in the flags it has handled and a one in the enable bit. That single read-modify-write both services the faults and re-arms the interrupt.

Top module: `irq_status_reg`

## Requirements
- R1: A one-cycle pulse on an event input sets its flag at the next rising clock edge. The flags sit at these status bits: memory parity error at 13, inhibited narrow write at 12, receiver sync loss at 11, receive FIFO full at 10, receive FIFO almost full at 9, bad receive data at 8.
- R2: A set flag stays set until a status write carries a zero at its bit position. The flag then reads zero after that write's clock edge.
- R3: A status write with a one at a flag's position leaves that flag unchanged, whether it was set or clear.
- R4: When an event pulse and a status write with a zero at the same flag occur in the same cycle, the flag ends up set.
- R5: The global enable is status bit 31. A status write loads it from bit 31 of the write data. A status read strobe with no write clears it at the next edge. The read data in the strobe cycle still shows the old value. If a read and a write occur in the same cycle, the written value wins.
- R6: The mask word enables the flag at the same bit position (bits 13 to 8). Those bits are loaded by a mask write and returned on the mask read data.
- R7: The interrupt output is high exactly when the global enable is set and at least one flag is set whose mask bit is also set.
- R8: Status bits 30 to 14 and 7 to 0, and mask bits other than 13 to 8, always read as zero and ignore writes.
- R9: After reset, all flags, the global enable and the mask are zero, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_parity | input | 1 | Memory parity error pulse |
| evt_wr_inhibit | input | 1 | Inhibited narrow write pulse |
| evt_sync_loss | input | 1 | Receiver sync loss pulse |
| evt_fifo_full | input | 1 | Receive FIFO full pulse |
| evt_fifo_afull | input | 1 | Receive FIFO almost full pulse |
| evt_bad_data | input | 1 | Bad receive data pulse |
| stat_rd | input | 1 | Status read strobe (clears global enable) |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 32 | Status write data |
| stat_rdata | output | 32 | Status read data |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 32 | Mask write data |
| mask_rdata | output | 32 | Mask read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a collision in one cycle: an event pulse arriving in the same cycle as a write-zero to its flag, or a read strobe arriving together with a write of the enable. The bench drives both strobes in the same low clock phase so that they meet at one edge. It then checks that the event survives and that the written enable overrides the read clear. The read-modify-write handshake is also run end to end, sampling the read data inside the strobe cycle before the enable drops.

// File: rtl/irq_stat_pkg.sv
// Shared sizing and bit positions for the sticky status register.
// Assumes a 32-bit word; flag positions are fixed by software decode.
package irq_stat_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_FLAGS = 6;
    localparam int FLAG_LSB  = 8;
    localparam int GIE_BIT   = 31;
endpackage

// File: rtl/irq_sticky_flag.sv
// One sticky fault flag: set by an event pulse, cleared by a write of zero.
// Assumes evt is a synchronous single-cycle pulse; an event wins over a clear.
module irq_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic wr,
    input  logic wr_bit,
    output logic q
);
    // Flag update: event has priority over write-zero clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              q <= 1'b0;
        else if (evt)            q <= 1'b1;
        else if (wr && !wr_bit)  q <= 1'b0;
    end

    // R1 R4
    set_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> q);
    // R2
    zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wr_bit && !evt) |=> !q);
    // R3
    one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_bit && !evt) |=> $stable(q));
endmodule

// File: rtl/irq_gie_ctrl.sv
// Global interrupt enable: loaded by status writes, dropped by status reads.
// Assumes a write in the same cycle as a read takes priority.
module irq_gie_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic rd,
    input  logic wr,
    input  logic wr_bit,
    output logic gie
);
    // Enable update: write loads, lone read clears.
    always_ff @(posedge clk) begin
        if (!rst_n)   gie <= 1'b0;
        else if (wr)  gie <= wr_bit;
        else if (rd)  gie <= 1'b0;
    end

    // R5
    read_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr) |=> !gie);
    // R5
    write_loads_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (gie == $past(wr_bit)));
endmodule

// File: rtl/irq_mask_reg.sv
// Interrupt mask word; only WIDTH bits are stored, the rest are not kept.
// Assumes a plain synchronous write strobe.
module irq_mask_reg #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mask
);
    // Mask storage: load on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)   mask <= '0;
        else if (wr)  mask <= wdata;
    end

    // R6
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (mask == $past(wdata)));
endmodule

// File: rtl/irq_merge.sv
// Interrupt combine: enable AND any masked flag.
// Assumes flags and mask are aligned bit for bit.
module irq_merge #(
    parameter int WIDTH = 6
) (
    input  logic [WIDTH-1:0] flags,
    input  logic [WIDTH-1:0] mask,
    input  logic             gie,
    output logic             irq
);
    // Request: any enabled flag while global enable is high.
    always_comb irq = gie && ((flags & mask) != '0);
endmodule

// File: rtl/irq_status_reg.sv
// Sticky fault status register with global enable and mask-gated interrupt.
// Assumes single-cycle event pulses and single-cycle register strobes,
// all synchronous to clk. Read data is combinational from held state.
module irq_status_reg
    import irq_stat_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt_parity,
    input  logic         evt_wr_inhibit,
    input  logic         evt_sync_loss,
    input  logic         evt_fifo_full,
    input  logic         evt_fifo_afull,
    input  logic         evt_bad_data,
    input  logic         stat_rd,
    input  logic         stat_wr,
    input  logic [W-1:0] stat_wdata,
    output logic [W-1:0] stat_rdata,
    input  logic         mask_wr,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] mask_rdata,
    output logic         irq
);
    localparam int NF = NUM_FLAGS;

    logic [NF-1:0] evt_vec;
    logic [NF-1:0] flags;
    logic [NF-1:0] mask;
    logic          gie;

    // Event bundle: index 0 maps to the lowest flag bit.
    always_comb evt_vec = {evt_parity, evt_wr_inhibit, evt_sync_loss,
                           evt_fifo_full, evt_fifo_afull, evt_bad_data};

    genvar i;
    generate
        for (i = 0; i < NF; i++) begin : g_flag
            irq_sticky_flag u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .evt    (evt_vec[i]),
                .wr     (stat_wr),
                .wr_bit (stat_wdata[FLAG_LSB+i]),
                .q      (flags[i])
            );
        end
    endgenerate

    irq_gie_ctrl u_gie (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (stat_rd),
        .wr     (stat_wr),
        .wr_bit (stat_wdata[GIE_BIT]),
        .gie    (gie)
    );

    irq_mask_reg #(.WIDTH(NF)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (mask_wr),
        .wdata (mask_wdata[FLAG_LSB +: NF]),
        .mask  (mask)
    );

    irq_merge #(.WIDTH(NF)) u_merge (
        .flags (flags),
        .mask  (mask),
        .gie   (gie),
        .irq   (irq)
    );

    // Status read word: flags and enable, all other bits zero.
    always_comb begin
        stat_rdata                  = '0;
        stat_rdata[FLAG_LSB +: NF]  = flags;
        stat_rdata[GIE_BIT]         = gie;
    end

    // Mask read word: stored mask bits only.
    always_comb begin
        mask_rdata                  = '0;
        mask_rdata[FLAG_LSB +: NF]  = mask;
    end

    // R7
    irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gie);
    // R5
    rd_shows_old_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !stat_wr && stat_rdata[GIE_BIT]) |=> !stat_rdata[GIE_BIT]);
endmodule

// File: tb/tb_irq_status_reg.sv
// Bench: table-driven event/mask/interrupt vectors, then directed corners.
module tb_irq_status_reg;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;
    // Entry: {evt[5:0] (bit5=parity..bit0=bad data), mask[5:0], gie, exp_irq}
    localparam logic [13:0] VEC [NV] = '{
        {6'b100000, 6'b100000, 1'b1, 1'b1},
        {6'b010000, 6'b000000, 1'b1, 1'b0},
        {6'b001000, 6'b001000, 1'b0, 1'b0},
        {6'b000100, 6'b111111, 1'b1, 1'b1},
        {6'b000010, 6'b000001, 1'b1, 1'b0},
        {6'b000001, 6'b000001, 1'b1, 1'b1},
        {6'b110011, 6'b001100, 1'b1, 1'b0},
        {6'b101010, 6'b001010, 1'b1, 1'b1},
        {6'b000000, 6'b111111, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_parity = 0, evt_wr_inhibit = 0, evt_sync_loss = 0;
    logic        evt_fifo_full = 0, evt_fifo_afull = 0, evt_bad_data = 0;
    logic        stat_rd = 0, stat_wr = 0, mask_wr = 0;
    logic [31:0] stat_wdata = '0, mask_wdata = '0;
    logic [31:0] stat_rdata, mask_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    irq_status_reg dut (
        .clk(clk), .rst_n(rst_n),
        .evt_parity(evt_parity), .evt_wr_inhibit(evt_wr_inhibit),
        .evt_sync_loss(evt_sync_loss), .evt_fifo_full(evt_fifo_full),
        .evt_fifo_afull(evt_fifo_afull), .evt_bad_data(evt_bad_data),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .stat_rdata(stat_rdata), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .mask_rdata(mask_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got %0d cycles, expected < 20000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic set_evts(input logic [5:0] e);
        {evt_parity, evt_wr_inhibit, evt_sync_loss,
         evt_fifo_full, evt_fifo_afull, evt_bad_data} = e;
    endtask

    task automatic pulse_evt(input logic [5:0] e);
        @(negedge clk); set_evts(e);
        @(negedge clk); set_evts(6'b0);
    endtask

    task automatic wr_stat(input logic [31:0] d);
        @(negedge clk); stat_wr = 1'b1; stat_wdata = d;
        @(negedge clk); stat_wr = 1'b0; stat_wdata = '0;
    endtask

    task automatic wr_mask(input logic [31:0] d);
        @(negedge clk); mask_wr = 1'b1; mask_wdata = d;
        @(negedge clk); mask_wr = 1'b0; mask_wdata = '0;
    endtask

    initial begin
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 status", stat_rdata, 32'h0);
        check("R9 mask", mask_rdata, 32'h0);
        check("R9 irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;

        // Table walk: R1 flag mapping, R6 mask, R7 interrupt
        for (int k = 0; k < NV; k++) begin
            wr_mask({18'b0, VEC[k][7:2], 8'b0});
            wr_stat({VEC[k][1], 31'b0});
            pulse_evt(VEC[k][13:8]);
            check("R1 flags", {26'b0, stat_rdata[13:8]}, {26'b0, VEC[k][13:8]});
            check("R6 mask", mask_rdata, {18'b0, VEC[k][7:2], 8'b0});
            check("R7 irq", {31'b0, irq}, {31'b0, VEC[k][0]});
        end

        // R2 flag persists, then write-zero clears it
        wr_stat(32'h0);
        pulse_evt(6'b100000);
        repeat (3) @(negedge clk);
        check("R2 hold", stat_rdata, 32'h0000_2000);
        wr_stat(32'h0000_0000);
        check("R2 clear", stat_rdata, 32'h0);

        // R3 write-one keeps set flag set and clear flag clear
        pulse_evt(6'b000001);
        wr_stat(32'h0000_3F00);
        check("R3 keep", stat_rdata, 32'h0000_0100);

        // R4 event and write-zero in same cycle
        @(negedge clk); set_evts(6'b000001); stat_wr = 1'b1; stat_wdata = 32'h0;
        @(negedge clk); set_evts(6'b0); stat_wr = 1'b0;
        check("R4 event wins", stat_rdata, 32'h0000_0100);

        // R5 read-modify-write: read shows old enable, then enable drops
        wr_mask(32'h0000_0100);
        wr_stat(32'h8000_0100);
        check("R7 irq armed", {31'b0, irq}, 32'h1);
        @(negedge clk); stat_rd = 1'b1;
        #1 snap = stat_rdata;
        check("R5 read old gie", snap, 32'h8000_0100);
        @(negedge clk); stat_rd = 1'b0;
        check("R5 gie dropped", stat_rdata, 32'h0000_0100);
        check("R7 irq off", {31'b0, irq}, 32'h0);
        wr_stat(snap & 32'hFFFF_FEFF);
        check("R5 rmw rearm", stat_rdata, 32'h8000_0000);

        // R5 read and write in the same cycle: write wins
        @(negedge clk); stat_rd = 1'b1; stat_wr = 1'b1; stat_wdata = 32'h8000_0000;
        @(negedge clk); stat_rd = 1'b0; stat_wr = 1'b0;
        check("R5 wr beats rd", stat_rdata, 32'h8000_0000);

        // R8 unused bits read zero
        wr_stat(32'h0);
        wr_stat(32'h7FFF_C0FF);
        check("R8 status unused", stat_rdata, 32'h0);
        wr_mask(32'hFFFF_FFFF);
        check("R8 mask unused", mask_rdata, 32'h0000_3F00);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule